// File: doc/BRIEF.md
# Flash readout protection controller

This block sits between an on-chip flash array and its requesters. Each read, program or erase request is checked against the current protect level and against the access mode it arrives in. The modes are external parallel programming, CPU self-rewrite and factory tester. The block forwards a permitted request to the flash as a one-cycle strobe. It answers every request with a one-cycle grant or deny pulse in the following cycle.

The protect level comes from a control byte stored at a fixed offset inside the first flash block. Right after reset is released, the block fetches that byte and decodes it into off, level 1 or level 2. The first block can only be rewritten as a whole: an erase of the block, then programs of every word in ascending order. The block keeps a shadow copy of the control byte while that sequence runs. It moves the new level into effect only when the last word of the block has been programmed. A half-finished rewrite therefore never changes the protection.

Top module: `flash_guard`

## Requirements
- R1: The control byte is decoded with the level-1 enable pair at bits 7:6, the override pair at bits 5:4 and the level-2 enable pair at bits 3:2. A level is requested when its pair is anything but 11. An override pair of 00 forces the level to off. When both levels are requested, the reported level is 2. `level_o` encodes off as 0, level 1 as 1 and level 2 as 2.
- R2: While reset is held, and for two cycles after it is released, `level_o` reads 2. During those two cycles the block reads the control byte at address `CTRL_OFS` (default 0x0B). From the third cycle after release, `level_o` shows the decoded level. Requests sampled before then are denied.
- R3: In external mode (`mode_i` 00, and the unused code 11), every request is denied while the level is not off. This includes any erase or program that would alter the override pair. At level off, external requests follow the same rules as CPU mode.
- R4: In tester mode (`mode_i` 10), reads are granted at levels off and 1 and denied at level 2. Program and erase are always denied.
- R5: In CPU mode (`mode_i` 01), reads, erases and programs are granted at every level, subject to R6.
- R6: The first block is the set of addresses whose bits above `BLK_W` are zero (default 0x00 to 0x0F). An erase (`cmd_i` 10) clears the whole block holding `addr_i`. A program (`cmd_i` 01) into the first block is granted only after a granted erase of that block, and only at the next ascending address starting from the block base. Any other program there is denied, including a lone program of the control byte.
- R7: The level changes only when the last word of the first block is programmed in a granted sequence. The new level is decoded from the byte programmed at the control offset in that sequence. An erase on its own leaves the level unchanged.
- R8: Each request sampled at a clock edge produces exactly one outcome: `grant_o` or `deny_o` high for the single following cycle. Neither is raised without a request. A reserved command (`cmd_i` 11) is always denied.
- R9: A denied request raises no flash read, program or erase strobe. `rdata_o` is all ones except in the grant cycle of a read, when it carries the flash data.
- R10: A granted read of the control byte address returns bits 1:0 as 1, whatever is stored there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Access mode: 00 external, 01 CPU, 10 tester, 11 treated as external |
| req_i | input | 1 | Request strobe, one request per cycle when high |
| cmd_i | input | 2 | 00 read, 01 program, 10 erase block, 11 reserved |
| addr_i | input | ADDR_W | Flash word address |
| wdata_i | input | 8 | Program data |
| grant_o | output | 1 | Request granted (cycle after request) |
| deny_o | output | 1 | Request denied (cycle after request) |
| rdata_o | output | 8 | Read data in a read grant cycle, otherwise all ones |
| level_o | output | 2 | Current protect level |
| fl_addr_o | output | ADDR_W | Address to the flash array |
| fl_rd_o | output | 1 | Flash read strobe; data is expected on fl_rdata_i the next cycle |
| fl_prog_o | output | 1 | Flash program strobe |
| fl_erase_o | output | 1 | Flash block erase strobe |
| fl_wdata_o | output | 8 | Program data to the flash array |
| fl_rdata_i | input | 8 | Registered read data from the flash array |

## Verification
A wrong decode of the fetched byte shows on `level_o` from the third cycle after reset is released. It then turns the very next external or tester request into the wrong outcome. A sequence tracker that has lost its place denies a program in the middle of the first block. The fault is visible one cycle later, and again as a level that fails to change after the last word. A tracker that commits early moves `level_o` before the final program. The bench reads the level between every word of the rewrite to catch that.

// File: rtl/fg_pkg.sv
package fg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_EXT  = 2'b00,
        MODE_CPU  = 2'b01,
        MODE_TEST = 2'b10,
        MODE_ALT  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_RSV   = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        LVL_OFF = 2'd0,
        LVL_ONE = 2'd1,
        LVL_TWO = 2'd2
    } lvl_e;

    typedef enum logic [1:0] {
        LD_FETCH   = 2'd0,
        LD_CAPTURE = 2'd1,
        LD_RUN     = 2'd2
    } ld_e;

    // Stored protection byte, most significant field first.
    typedef struct packed {
        logic [1:0] en_one;
        logic [1:0] unlock;
        logic [1:0] en_two;
        logic [1:0] spare;
    } guard_byte_t;

    function automatic lvl_e decode_guard(input logic [BYTE_W-1:0] raw);
        guard_byte_t g;
        lvl_e        l;
        g = guard_byte_t'(raw);
        if (g.unlock == 2'b00)
            l = LVL_OFF;
        else if (g.en_two != 2'b11)
            l = LVL_TWO;
        else if (g.en_one != 2'b11)
            l = LVL_ONE;
        else
            l = LVL_OFF;
        return l;
    endfunction

endpackage

// File: rtl/fg_loader.sv
module fg_loader
    import fg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] fl_rdata_i,
    input  logic              commit_i,
    input  logic [BYTE_W-1:0] commit_byte_i,
    output logic              fetch_o,
    output logic              run_o,
    output lvl_e              level_o
);

    ld_e  st_q;
    lvl_e lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LD_FETCH;
            lvl_q <= LVL_TWO;
        end else begin
            case (st_q)
                LD_FETCH:   st_q <= LD_CAPTURE;
                LD_CAPTURE: begin
                    lvl_q <= decode_guard(fl_rdata_i);
                    st_q  <= LD_RUN;
                end
                default: begin
                    if (commit_i)
                        lvl_q <= decode_guard(commit_byte_i);
                end
            endcase
        end
    end

    assign fetch_o = (st_q == LD_FETCH);
    assign run_o   = (st_q == LD_RUN);
    assign level_o = lvl_q;

    // R1
    level_legal_chk: assert property (@(posedge clk) disable iff (rst)
        2'(lvl_q) != 2'b11);

    // R2
    run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        run_o |=> run_o);

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_o && !commit_i) |=> (lvl_q == $past(lvl_q)));

endmodule

// File: rtl/fg_seq.sv
module fg_seq
    import fg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BLK_W    = 4,
    parameter int CTRL_OFS = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  op_e               op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic              blk0_ok_o,
    output logic              commit_o,
    output logic [BYTE_W-1:0] commit_byte_o
);

    localparam logic [BLK_W-1:0] CTRL_IDX = BLK_W'(CTRL_OFS);
    localparam logic [BLK_W-1:0] LAST_IDX = {BLK_W{1'b1}};

    logic              armed_q;
    logic [BLK_W-1:0]  nxt_q;
    logic [BYTE_W-1:0] shadow_q;
    logic [BYTE_W-1:0] shadow_nx;
    logic              in_blk0;
    logic [BLK_W-1:0]  ofs;

    assign in_blk0   = (addr_i[ADDR_W-1:BLK_W] == '0);
    assign ofs       = addr_i[BLK_W-1:0];
    assign blk0_ok_o = armed_q && (ofs == nxt_q);
    assign shadow_nx = (ofs == CTRL_IDX) ? wdata_i : shadow_q;

    assign commit_o      = take_i && (op_i == OP_PROG) && in_blk0 && armed_q && (nxt_q == LAST_IDX);
    assign commit_byte_o = shadow_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            nxt_q    <= '0;
            shadow_q <= '1;
        end else if (take_i && in_blk0) begin
            if (op_i == OP_ERASE) begin
                armed_q  <= 1'b1;
                nxt_q    <= '0;
                shadow_q <= '1;
            end else if (op_i == OP_PROG) begin
                shadow_q <= shadow_nx;
                if (nxt_q == LAST_IDX) begin
                    armed_q <= 1'b0;
                    nxt_q   <= '0;
                end else begin
                    nxt_q <= nxt_q + 1'b1;
                end
            end
        end
    end

    // R6
    blk0_order_chk: assert property (@(posedge clk) disable iff (rst)
        (take_i && op_i == OP_PROG && in_blk0) |-> (armed_q && ofs == nxt_q));

    // R7
    commit_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> !armed_q);

endmodule

// File: rtl/fg_policy.sv
module fg_policy
    import fg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 4
) (
    input  logic              run_i,
    input  mode_e             mode_i,
    input  op_e               op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  lvl_e              level_i,
    input  logic              blk0_ok_i,
    output logic              allow_o
);

    logic in_blk0;
    logic blk_rule;

    always_comb begin
        in_blk0  = (addr_i[ADDR_W-1:BLK_W] == '0);
        blk_rule = !((op_i == OP_PROG) && in_blk0) || blk0_ok_i;
        allow_o  = 1'b0;
        if (run_i && op_i != OP_RSV) begin
            case (mode_i)
                MODE_CPU:  allow_o = blk_rule;
                MODE_TEST: allow_o = (op_i == OP_READ) && (level_i != LVL_TWO);
                default:   allow_o = (level_i == LVL_OFF) && blk_rule;
            endcase
        end
    end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import fg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BLK_W    = 4,
    parameter int CTRL_OFS = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              req_i,
    input  logic [1:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic              grant_o,
    output logic              deny_o,
    output logic [7:0]        rdata_o,
    output logic [1:0]        level_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic              fl_rd_o,
    output logic              fl_prog_o,
    output logic              fl_erase_o,
    output logic [7:0]        fl_wdata_o,
    input  logic [7:0]        fl_rdata_i
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFS);
    localparam logic [7:0]        SPARE_ONES = 8'h03;

    mode_e             mode;
    op_e               op;
    lvl_e              level;
    logic              run, fetch, allow, take;
    logic              blk0_ok, commit;
    logic [BYTE_W-1:0] commit_byte;
    logic              grant_q, deny_q, rd_q, ctrl_q;

    assign mode = mode_e'(mode_i);
    assign op   = op_e'(cmd_i);

    fg_loader u_loader (
        .clk           (clk),
        .rst           (rst),
        .fl_rdata_i    (fl_rdata_i),
        .commit_i      (commit),
        .commit_byte_i (commit_byte),
        .fetch_o       (fetch),
        .run_o         (run),
        .level_o       (level)
    );

    fg_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .CTRL_OFS(CTRL_OFS)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .take_i        (take),
        .op_i          (op),
        .addr_i        (addr_i),
        .wdata_i       (wdata_i),
        .blk0_ok_o     (blk0_ok),
        .commit_o      (commit),
        .commit_byte_o (commit_byte)
    );

    fg_policy #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_policy (
        .run_i     (run),
        .mode_i    (mode),
        .op_i      (op),
        .addr_i    (addr_i),
        .level_i   (level),
        .blk0_ok_i (blk0_ok),
        .allow_o   (allow)
    );

    assign take       = req_i && allow;
    assign fl_addr_o  = fetch ? CTRL_ADDR : addr_i;
    assign fl_rd_o    = fetch || (take && op == OP_READ);
    assign fl_prog_o  = take && (op == OP_PROG);
    assign fl_erase_o = take && (op == OP_ERASE);
    assign fl_wdata_o = wdata_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
            rd_q    <= 1'b0;
            ctrl_q  <= 1'b0;
        end else begin
            grant_q <= take;
            deny_q  <= req_i && !allow;
            rd_q    <= take && (op == OP_READ);
            ctrl_q  <= (addr_i == CTRL_ADDR);
        end
    end

    assign grant_o = grant_q;
    assign deny_o  = deny_q;
    assign level_o = 2'(level);
    assign rdata_o = !rd_q ? '1 : (ctrl_q ? (fl_rdata_i | SPARE_ONES) : fl_rdata_i);

    // R8
    outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(grant_o && deny_o));

    // R8
    outcome_follows_chk: assert property (@(posedge clk) disable iff (rst)
        req_i |=> (grant_o || deny_o));

    // R8
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !(grant_o || deny_o));

    // R3
    ext_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && (mode == MODE_EXT || mode == MODE_ALT) && level != LVL_OFF) |=> deny_o);

    // R4
    tester_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode == MODE_TEST && op != OP_READ) |=> deny_o);

    // R9
    quiet_deny_chk: assert property (@(posedge clk) disable iff (rst)
        deny_o |-> $past(!fl_prog_o && !fl_erase_o));

    // R9
    deny_ones_chk: assert property (@(posedge clk) disable iff (rst)
        deny_o |-> (rdata_o == 8'hFF));

endmodule

// File: tb/flash_guard_test.sv
module flash_guard_test;

    localparam int CLK_PERIOD = 10;

    localparam logic [1:0] M_EXT = 2'b00, M_CPU = 2'b01, M_TST = 2'b10, M_ALT = 2'b11;
    localparam logic [1:0] C_RD = 2'b00, C_PG = 2'b01, C_ER = 2'b10, C_RS = 2'b11;
    localparam logic [7:0] CTRL = 8'h0B;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       req = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic       grant, deny;
    logic [7:0] rdata;
    logic [1:0] level;
    logic [7:0] fl_addr, fl_wdata, fl_rdata;
    logic       fl_rd, fl_prog, fl_erase;

    logic       preload = 1'b0;
    logic [7:0] pre_byte = 8'hFF;
    logic [7:0] mem [256];
    logic [7:0] rd_reg = 8'hFF;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    typedef struct {
        bit         g;
        logic [7:0] rd;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_guard uut (
        .clk(clk), .rst(rst), .mode_i(mode), .req_i(req), .cmd_i(cmd),
        .addr_i(addr), .wdata_i(wdata), .grant_o(grant), .deny_o(deny),
        .rdata_o(rdata), .level_o(level), .fl_addr_o(fl_addr), .fl_rd_o(fl_rd),
        .fl_prog_o(fl_prog), .fl_erase_o(fl_erase), .fl_wdata_o(fl_wdata),
        .fl_rdata_i(fl_rdata)
    );

    // Flash stand-in: registered read, direct program, block erase of 16 words.
    always @(posedge clk) begin
        if (preload) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
            mem[CTRL] <= pre_byte;
        end else begin
            if (fl_erase)
                for (int i = 0; i < 16; i++) mem[{fl_addr[7:4], 4'(i)}] <= 8'hFF;
            if (fl_prog) mem[fl_addr] <= fl_wdata;
            if (fl_rd) rd_reg <= mem[fl_addr];
        end
    end
    assign fl_rdata = rd_reg;

    function automatic logic [1:0] want_level(input logic [7:0] b);
        bit one, two;
        one = (b[7:6] != 2'b11);
        two = (b[3:2] != 2'b11);
        if (b[5:4] == 2'b00) return 2'd0;
        if (two) return 2'd2;
        if (one) return 2'd1;
        return 2'd0;
    endfunction

    // Monitor: pop one expected outcome per observed pulse.
    always @(posedge clk) begin
        #1;
        if (!rst && (grant || deny)) begin
            compared++;
            if (sb.size() == 0) begin
                mismatched++;
                $display("FAIL R8 unexpected outcome: actual grant=%0b deny=%0b expected none", grant, deny);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (grant !== e.g || deny !== !e.g || rdata !== e.rd) begin
                    mismatched++;
                    $display("FAIL %s: actual grant=%0b deny=%0b rdata=%h expected grant=%0b rdata=%h",
                             e.tag, grant, deny, rdata, e.g, e.rd);
                end
            end
        end
    end

    task automatic issue(input logic [1:0] m, input logic [1:0] c, input logic [7:0] a,
                         input logic [7:0] d, input bit g, input logic [7:0] er, input string tag);
        exp_t e;
        @(negedge clk);
        mode = m; cmd = c; addr = a; wdata = d; req = 1'b1;
        e.g = g; e.rd = er; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic chk_level(input logic [1:0] exp, input string tag);
        @(negedge clk);
        compared++;
        if (level !== exp) begin
            mismatched++;
            $display("FAIL %s: actual level=%0d expected %0d", tag, level, exp);
        end
    endtask

    task automatic boot(input logic [7:0] b, input bit early_req);
        @(negedge clk);
        rst = 1'b1; preload = 1'b1; pre_byte = b; req = 1'b0;
        repeat (3) @(negedge clk);
        compared++;
        if (level !== 2'd2) begin
            mismatched++;
            $display("FAIL R2 level in reset: actual %0d expected 2", level);
        end
        preload = 1'b0; rst = 1'b0;
        if (early_req) begin
            exp_t e;
            mode = M_CPU; cmd = C_RD; addr = 8'h20; req = 1'b1;
            e.g = 1'b0; e.rd = 8'hFF; e.tag = "R2 request during boot";
            sb.push_back(e);
        end
        @(negedge clk);
        req = 1'b0;
        compared++;
        if (level !== 2'd2) begin
            mismatched++;
            $display("FAIL R2 level during fetch: actual %0d expected 2", level);
        end
        chk_level(want_level(b), "R1 R2 decoded level after boot");
    endtask

    // Full first-block rewrite; control word gets cb, others 0x10+i.
    task automatic rewrite_blk0(input logic [1:0] m, input logic [7:0] cb, input logic [1:0] lvl_before);
        issue(m, C_ER, 8'h07, 8'h00, 1'b1, 8'hFF, "R6 erase first block");
        chk_level(lvl_before, "R7 erase alone keeps level");
        for (int i = 0; i < 16; i++) begin
            issue(m, C_PG, 8'(i), (8'(i) == CTRL) ? cb : 8'h10 + 8'(i), 1'b1, 8'hFF, "R6 ordered program");
            if (i == 14) chk_level(lvl_before, "R7 level held before last word");
        end
        chk_level(want_level(cb), "R7 level after last word");
    endtask

    initial begin
        // Erased part: unprotected.
        boot(8'hFF, 1'b0);
        issue(M_EXT, C_RD, 8'h20, 8'h00, 1'b1, 8'hFF, "R3 ext read unprotected");
        issue(M_EXT, C_PG, 8'h20, 8'h5A, 1'b1, 8'hFF, "R3 ext program unprotected");
        issue(M_EXT, C_RD, 8'h20, 8'h00, 1'b1, 8'h5A, "R3 ext readback");
        issue(M_EXT, C_RS, 8'h20, 8'h00, 1'b0, 8'hFF, "R8 reserved command");
        issue(M_TST, C_RD, 8'h20, 8'h00, 1'b1, 8'h5A, "R4 tester read at off");

        // Spare bits stored as 0 read back as 1.
        boot(8'hFC, 1'b0);
        issue(M_EXT, C_RD, CTRL, 8'h00, 1'b1, 8'hFF, "R10 spare bits forced");
        issue(M_CPU, C_RD, CTRL, 8'h00, 1'b1, 8'hFF, "R10 spare bits forced cpu");

        // Level 1.
        boot(8'h3F, 1'b0);
        issue(M_EXT, C_RD, 8'h20, 8'h00, 1'b0, 8'hFF, "R3 ext read locked");
        issue(M_EXT, C_PG, 8'h30, 8'h11, 1'b0, 8'hFF, "R3 ext program locked");
        issue(M_EXT, C_ER, 8'h30, 8'h00, 1'b0, 8'hFF, "R3 ext erase locked");
        issue(M_ALT, C_RD, 8'h20, 8'h00, 1'b0, 8'hFF, "R3 alt mode locked");
        issue(M_TST, C_RD, CTRL, 8'h00, 1'b1, 8'h3F, "R4 tester read at level 1");
        issue(M_TST, C_PG, 8'h30, 8'h22, 1'b0, 8'hFF, "R4 tester program denied");
        issue(M_CPU, C_RD, 8'h30, 8'h00, 1'b1, 8'hFF, "R9 denied program left memory");
        issue(M_CPU, C_PG, 8'h30, 8'h77, 1'b1, 8'hFF, "R5 cpu program");
        issue(M_CPU, C_RD, 8'h30, 8'h00, 1'b1, 8'h77, "R5 cpu readback");
        issue(M_CPU, C_PG, CTRL, 8'hFF, 1'b0, 8'hFF, "R6 lone control program");
        issue(M_CPU, C_PG, 8'h00, 8'h01, 1'b0, 8'hFF, "R6 unarmed program");
        issue(M_CPU, C_RD, CTRL, 8'h00, 1'b1, 8'h3F, "R6 control unchanged");
        chk_level(2'd1, "R6 level unchanged after refused writes");
        // Out-of-order program inside a sequence.
        issue(M_CPU, C_ER, 8'h00, 8'h00, 1'b1, 8'hFF, "R6 erase");
        issue(M_CPU, C_PG, 8'h00, 8'h10, 1'b1, 8'hFF, "R6 first word");
        issue(M_CPU, C_PG, 8'h02, 8'h12, 1'b0, 8'hFF, "R6 skipped word denied");
        chk_level(2'd1, "R7 level held mid sequence");
        rewrite_blk0(M_CPU, 8'hFF, 2'd1);
        issue(M_CPU, C_RD, 8'h03, 8'h00, 1'b1, 8'h13, "R6 block data written");

        // Unprotected external rewrite to level 2, then locked.
        rewrite_blk0(M_EXT, 8'hF3, 2'd0);
        issue(M_TST, C_RD, 8'h03, 8'h00, 1'b0, 8'hFF, "R4 tester read at level 2");
        issue(M_EXT, C_ER, 8'h00, 8'h00, 1'b0, 8'hFF, "R3 override cannot change externally");
        issue(M_CPU, C_RD, CTRL, 8'h00, 1'b1, 8'hF3, "R5 cpu read at level 2");

        boot(8'h33, 1'b0);  // both levels -> 2
        boot(8'h0F, 1'b0);  // override clears
        boot(8'h03, 1'b0);  // all pairs zero with override -> off
        boot(8'h7F, 1'b0);  // single zero bit -> level 1
        boot(8'hF3, 1'b1);  // request during boot denied

        repeat (3) @(negedge clk);
        compared++;
        if (sb.size() != 0) begin
            mismatched++;
            $display("FAIL R8 missing outcomes: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule